// File: doc/BRIEF.md
# Fast Ethernet PHY Management Register File

This block holds the management registers of a Fast Ethernet transceiver and serves them through a parallel access port. Each access carries a PHY address, a 5-bit register index, a read or a write strobe and a 16-bit data word. An access aimed at a PHY address other than the one strapped on `phy_addr` is not claimed: a read returns all ones and a write changes nothing.

Only two registers can be written: basic control (index 0) and local advertisement (index 4). Basic status (index 1) and link-partner ability (index 5) are built from fixed capability bits and a link flag. The link flag is registered from the `link_up` input on every clock. The two identifier words (indices 2 and 3) are parameters. Index 6 and every index from 7 to 31 read as zero and ignore writes. A control write with bit 15 set does not store the value. Instead it restores the control and advertisement registers to their reset contents. The link-dependent bits then keep following the current link flag.

A two-state access sequencer, ACC_IDLE and ACC_RESP, times the read response. From either state, a read strobe moves it to ACC_RESP, which drives `rd_valid` for one cycle with the captured word. With no read strobe it returns to ACC_IDLE (transitions: IDLE→RESP on read, RESP→RESP on back-to-back read, RESP→IDLE and IDLE→IDLE otherwise).

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the registers read as follows: control 0x3100 (bit 13 speed 100, bit 12 auto-negotiation enable, bit 8 full duplex), advertisement 0x01E1 (bits 8, 7, 6, 5 and selector bit 0), status 0x7848 (bits 14, 13, 12, 11, 6 and 3) while the link is down, and link-partner ability 0x0080.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_stb` high, and `rd_data` then holds the addressed word. Without a read strobe, `rd_valid` is low in the next cycle.
- R3: A read whose `acc_addr` differs from `phy_addr` returns 0xFFFF, and a write to such an address changes no register.
- R4: One clock after `link_up` rises, status reads 0x786C (link bit 2 and auto-negotiation-complete bit 5 added) and link-partner ability reads 0x01E1. One clock after it falls, the values return to 0x7848 and 0x0080.
- R5: A control write with bit 15 clear stores the full 16-bit value, and any write to the advertisement register stores the full value. Both read back unchanged.
- R6: A control write with bit 15 set leaves control at 0x3100 and advertisement at 0x01E1, and status and link-partner ability still reflect the current link.
- R7: Writes to status, both identifier registers and link-partner ability leave their read values unchanged.
- R8: Indices 2 and 3 return the parameters `ID_HI` and `ID_LO` (defaults 0x0007 and 0xC0F1).
- R9: Index 6 and indices 7 to 31 read as 0 at the matching address, and writes to them have no effect on any register.
- R10: When read and write strobes coincide on the same register, the read returns the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link indication, sampled every clock |
| phy_addr | input | 5 | Address this PHY answers to |
| acc_addr | input | 5 | PHY address of the current access |
| acc_reg | input | 5 | Register index of the current access |
| rd_stb | input | 1 | Read request |
| wr_stb | input | 1 | Write request |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | One-cycle read response flag |

## Verification
A corrupted control or advertisement register stays hidden until the next read of index 0 or 4. That read shows the wrong word on `rd_data` one cycle after its strobe. A stale link flag appears in the status and partner-ability words on the first read issued after the clock that should have updated it. The bench therefore reads all 32 indices after every change of state: after reset, after a write sweep, after each link change and after a soft reset. Any damaged bit is then seen within one read sweep.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int DW = 16;
    localparam int SOFT_RST_BIT = 15;

    typedef enum logic [2:0] {
        RC_CTRL,
        RC_STAT,
        RC_ID_HI,
        RC_ID_LO,
        RC_ADV,
        RC_LPA,
        RC_ZERO
    } reg_cls_e;

    typedef enum logic {
        ACC_IDLE,
        ACC_RESP
    } acc_state_e;

    localparam logic [DW-1:0] CTRL_RST  = 16'h3100;
    localparam logic [DW-1:0] STAT_BASE = 16'h7848;
    localparam logic [DW-1:0] STAT_LINK = 16'h0024;
    localparam logic [DW-1:0] ADV_RST   = 16'h01E1;
    localparam logic [DW-1:0] LPA_BASE  = 16'h0080;
    localparam logic [DW-1:0] LPA_LINK  = 16'h0161;
    localparam logic [DW-1:0] NO_RESP   = 16'hFFFF;
endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
    import phy_mgmt_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] acc_addr,
    input  logic [AW-1:0] acc_reg,
    output logic          hit,
    output reg_cls_e      cls
);
    assign hit = (cfg_addr == acc_addr);

    always_comb begin
        case (acc_reg)
            AW'(0):  cls = RC_CTRL;
            AW'(1):  cls = RC_STAT;
            AW'(2):  cls = RC_ID_HI;
            AW'(3):  cls = RC_ID_LO;
            AW'(4):  cls = RC_ADV;
            AW'(5):  cls = RC_LPA;
            default: cls = RC_ZERO;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_store.sv
module phy_mgmt_store
    import phy_mgmt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic          wr_en,
    input  reg_cls_e      cls,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ctrl_word,
    output logic [DW-1:0] adv_word,
    output logic [DW-1:0] stat_word,
    output logic [DW-1:0] lpa_word
);
    logic [DW-1:0] ctrl_r;
    logic [DW-1:0] adv_r;
    logic          link_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_r <= CTRL_RST;
            adv_r  <= ADV_RST;
            link_r <= 1'b0;
        end else begin
            link_r <= link_up;
            if (wr_en) begin
                case (cls)
                    RC_CTRL: begin
                        if (wr_data[SOFT_RST_BIT]) begin
                            ctrl_r <= CTRL_RST;
                            adv_r  <= ADV_RST;
                        end else begin
                            ctrl_r <= wr_data;
                        end
                    end
                    RC_ADV:  adv_r <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign ctrl_word = ctrl_r;
    assign adv_word  = adv_r;
    assign stat_word = link_r ? (STAT_BASE | STAT_LINK) : STAT_BASE;
    assign lpa_word  = link_r ? (LPA_BASE | LPA_LINK) : LPA_BASE;
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int            AW    = 5,
    parameter logic [15:0]   ID_HI = 16'h0007,
    parameter logic [15:0]   ID_LO = 16'hC0F1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic [AW-1:0] phy_addr,
    input  logic [AW-1:0] acc_addr,
    input  logic [AW-1:0] acc_reg,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [15:0]   wr_data,
    output logic [15:0]   rd_data,
    output logic          rd_valid
);
    logic          addr_hit;
    reg_cls_e      cls;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] anar_q;
    logic [DW-1:0] stat_w;
    logic [DW-1:0] lpa_w;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rd_data_q;
    acc_state_e    state_q;
    acc_state_e    state_d;

    phy_mgmt_decode #(.AW(AW)) u_dec (
        .cfg_addr (phy_addr),
        .acc_addr (acc_addr),
        .acc_reg  (acc_reg),
        .hit      (addr_hit),
        .cls      (cls)
    );

    phy_mgmt_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .wr_en     (wr_stb & addr_hit),
        .cls       (cls),
        .wr_data   (wr_data),
        .ctrl_word (ctrl_q),
        .adv_word  (anar_q),
        .stat_word (stat_w),
        .lpa_word  (lpa_w)
    );

    always_comb begin
        if (!addr_hit) begin
            rd_mux = NO_RESP;
        end else begin
            case (cls)
                RC_CTRL:  rd_mux = ctrl_q;
                RC_STAT:  rd_mux = stat_w;
                RC_ID_HI: rd_mux = ID_HI;
                RC_ID_LO: rd_mux = ID_LO;
                RC_ADV:   rd_mux = anar_q;
                RC_LPA:   rd_mux = lpa_w;
                default:  rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ACC_IDLE: state_d = rd_stb ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_stb ? ACC_RESP : ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ACC_IDLE;
            rd_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_stb) rd_data_q <= rd_mux;
        end
    end

    always_comb begin
        rd_valid = (state_q == ACC_RESP);
        rd_data  = rd_data_q;
    end
endmodule

module phy_mgmt_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic          hit,
    input logic [AW-1:0] acc_reg,
    input logic [15:0]   wr_data,
    input logic [15:0]   ctrl_q,
    input logic [15:0]   anar_q,
    input logic [15:0]   rd_data,
    input logic          rd_valid
);
    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    // R2
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);
    // R3
    foreign_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !hit) |=> (rd_data == 16'hFFFF));
    // R3
    foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !hit) |=> ($stable(ctrl_q) && $stable(anar_q)));
    // R6
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && hit && acc_reg == AW'(0) && wr_data[15])
        |=> (ctrl_q == 16'h3100 && anar_q == 16'h01E1));
    // R9
    zero_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && hit && acc_reg > AW'(5)) |=> (rd_data == 16'h0000));
endmodule

bind phy_mgmt_regs phy_mgmt_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .hit      (addr_hit),
    .acc_reg  (acc_reg),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .anar_q   (anar_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
    localparam logic [15:0] IDH = 16'h0007;
    localparam logic [15:0] IDL = 16'hC0F1;
    localparam logic [4:0]  MY_ADDR = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic [4:0]  phy_addr = MY_ADDR;
    logic [4:0]  acc_addr = '0;
    logic [4:0]  acc_reg = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_ctrl = 16'h3100;
    logic [15:0] m_adv  = 16'h01E1;
    logic        m_link = 1'b0;

    always #10 clk = ~clk;

    phy_mgmt_regs #(.AW(5), .ID_HI(IDH), .ID_LO(IDL)) uut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .phy_addr(phy_addr),
        .acc_addr(acc_addr), .acc_reg(acc_reg), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    function automatic logic [15:0] expect_word(input logic [4:0] a, input logic [4:0] r);
        if (a != MY_ADDR) return 16'hFFFF;
        case (r)
            5'd0: return m_ctrl;
            5'd1: return m_link ? 16'h786C : 16'h7848;
            5'd2: return IDH;
            5'd3: return IDL;
            5'd4: return m_adv;
            5'd5: return m_link ? 16'h01E1 : 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input string tag, input logic [4:0] a, input logic [4:0] r);
        @(negedge clk);
        acc_addr = a; acc_reg = r; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check({tag, " R2 valid"}, {15'd0, rd_valid}, 16'd1);
        check(tag, rd_data, expect_word(a, r));
    endtask

    task automatic do_write(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        acc_addr = a; acc_reg = r; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        if (a == MY_ADDR) begin
            if (r == 5'd0) begin
                if (d[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
                else m_ctrl = d;
            end else if (r == 5'd4) begin
                m_adv = d;
            end
        end
    endtask

    task automatic sweep(input string tag);
        for (int r = 0; r < 32; r++) do_read(tag, MY_ADDR, 5'(r));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", {15'd0, rd_valid}, 16'd0);

        // R1 R8 R9: reset contents of every index
        sweep("R1 R8 R9 reset sweep");

        // R2: valid drops after a single read
        do_read("R2 single", MY_ADDR, 5'd0);
        @(negedge clk);
        check("R2 valid low", {15'd0, rd_valid}, 16'd0);

        // R3: address match sweep
        for (int a = 0; a < 32; a++) do_read("R3 addr sweep", 5'(a), 5'd2);
        do_write(5'd9, 5'd0, 16'h1234);
        do_write(5'd9, 5'd4, 16'h4321);
        do_read("R3 foreign write ctrl", MY_ADDR, 5'd0);
        do_read("R3 foreign write adv", MY_ADDR, 5'd4);

        // R5 R7 R9: write every index, then read back
        for (int r = 0; r < 32; r++) do_write(MY_ADDR, 5'(r), 16'h0A50 ^ 16'(r));
        sweep("R5 R7 R9 write sweep");

        // R4: link up
        @(negedge clk); link_up = 1'b1; m_link = 1'b1;
        sweep("R4 link up");

        // R6: soft reset with link up
        do_write(MY_ADDR, 5'd4, 16'h0041);
        do_write(MY_ADDR, 5'd0, 16'h8000);
        sweep("R6 soft reset");

        // R4: link down
        @(negedge clk); link_up = 1'b0; m_link = 1'b0;
        do_read("R4 link down status", MY_ADDR, 5'd1);
        do_read("R4 link down lpa", MY_ADDR, 5'd5);

        // R10: coincident read and write
        @(negedge clk);
        acc_addr = MY_ADDR; acc_reg = 5'd4; wr_data = 16'h0321;
        rd_stb = 1'b1; wr_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        check("R10 old value", rd_data, m_adv);
        m_adv = 16'h0321;
        do_read("R10 new value", MY_ADDR, 5'd4);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule